// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block turns single bus operations into the SCL and SDA waveforms of an I2C master, counting every interval in cycles of its function clock. A sequencer above it presents one command at a time (START, write one bit, read one bit, STOP) on a valid/ready interface. The block answers each finished command with a one-clock `done` pulse and, for a read, the sampled bus value on `rd_bit`. Bytes, acknowledge policy, clock stretching and arbitration belong to that sequencer.

Two programmable words set the waveform. `clk_div` holds two dividers, and `tune` holds three small multipliers. The multipliers place the SDA update point inside the SCL low phase, stretch the START setup and hold windows and stretch the STOP setup window. Both words are captured when a command is accepted. SCL and SDA leave the block as open-drain pull-down enables: 1 pulls the line low and 0 releases it. Between commands inside a transfer the block holds SCL low. After reset and after a STOP it releases both lines.

The command interface is the only stream. `cmd_ready` is high while the block waits, and also during the last clock of a command that ends with SCL low or after a STOP. A command held valid in that clock is accepted on the same edge, so successive bits follow each other with no gap. `done` and `rd_bit` carry no back-pressure and must be taken when `done` is high.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset, and after a STOP completes, `scl_lo` and `sda_lo` are 0, `done` is 0 and `cmd_ready` is 1.
- R2: With l = low divider + 1 and h = high divider + 1, a bit command holds SCL low until 8·l clocks after the accepting edge. It then releases SCL for 8·h clocks and pulls it low again, 8·(l+h) clocks after acceptance.
- R3: For a write bit, with s = SDA field + 1, SDA takes the new value (`cmd_wdata` 1 releases, 0 pulls low) min(l·s+1, 8·l−1) clocks after acceptance. It does not change while SCL is high.
- R4: A read bit releases SDA from the accepting edge to the end of the bit. `rd_bit` takes the value `sda_in` had in the last clock of the SCL high phase.
- R5: A START accepted while the bus is free (both lines released), with u = START field + 1, pulls SDA low 8·h·u+1 clocks after acceptance. It pulls SCL low a further 8·h·(u+1)−1 clocks later.
- R6: A START accepted while SCL is held low (repeated START) releases SDA at the accepting edge and releases SCL 8·l clocks after acceptance. It then follows the R5 timing, counted from that SCL release.
- R7: A STOP, with p = STOP field + 1, pulls SDA low at the R3 update point and releases SCL 8·l clocks after acceptance. It releases SDA a further 8·h·p+1 clocks later, which returns the block to the state of R1.
- R8: `clk_div` carries the high divider in its upper half and the low divider in its lower half. `tune` carries the SDA field in bits 3:0, the START field in bits 5:4 and the STOP field in bits 7:6. A divider of 0 gives one unit (l or h = 1) and an all-ones divider gives the largest interval.
- R9: Command codes on `cmd_op` are 0 START, 1 write, 2 read and 3 STOP. A command is accepted only on an edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is also 1 in the final clock of a running command, so a back-to-back bit finds SCL low for exactly 8·l clocks.
- R10: Changes on `clk_div` or `tune` after acceptance do not alter the command in progress.
- R11: `done` is 1 for exactly one clock, on the clock after the edge that ends the command (the same edge that moves the last line).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Function clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this clock |
| cmd_op | input | 2 | Command code (R9) |
| cmd_wdata | input | 1 | Bit value for a write |
| clk_div | input | 2·DIV_W | High divider (upper half), low divider (lower half) |
| tune | input | 8 | SDA, START and STOP multiplier fields (R8) |
| sda_in | input | 1 | Sensed SDA line level |
| scl_lo | output | 1 | 1 pulls SCL low |
| sda_lo | output | 1 | 1 pulls SDA low |
| done | output | 1 | One-clock completion pulse |
| rd_bit | output | 1 | Last bit sampled by a read |

## Verification
Every deadline is counted from the edge that accepts the command, which is the bench's offset 0. An output moved by a register at edge k after that appears in the half-cycle sample numbered k. SCL, SDA and `done` each pass through exactly one register, so each expected offset is the formula of its requirement with no added latency. The bench steps one falling edge at a time and records the offset at which each line toggles and at which `done` appears, then compares these against the formulas. For the read bit it changes `sda_in` in the last high clock, so only a sample taken in that clock gives the expected value. For the back-to-back case it checks that `cmd_ready` rises exactly one clock before the first bit ends.

// File: rtl/i2cbt_pkg.sv
package i2cbt_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bt_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HOLD,
    ST_RS_LOW,
    ST_SU_STA,
    ST_HD_STA,
    ST_BIT_LOW,
    ST_BIT_HIGH,
    ST_SP_LOW,
    ST_SU_STO
  } bt_state_e;

  typedef enum logic [2:0] {
    PH_LOW,
    PH_HIGH,
    PH_SU_STA,
    PH_HD_STA,
    PH_SU_STO
  } bt_phase_e;

endpackage

// File: rtl/i2cbt_timing.sv
module i2cbt_timing
  import i2cbt_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int SDA_CFG_W = 4,
  parameter int STA_CFG_W = 2,
  parameter int STO_CFG_W = 2,
  parameter int CNT_W     = 23
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      load,
  input  logic [2*DIV_W-1:0]                        div_word,
  input  logic [SDA_CFG_W+STA_CFG_W+STO_CFG_W-1:0]  tune_word,
  input  bt_phase_e                                 phase,
  output logic [CNT_W-1:0]                          phase_len,
  output logic [CNT_W-1:0]                          upd_off
);

  localparam int MAXC = (STA_CFG_W > STO_CFG_W) ? STA_CFG_W : STO_CFG_W;
  localparam int MW   = DIV_W + SDA_CFG_W + MAXC + 6;

  logic [DIV_W-1:0]     dlow_q, dhigh_q;
  logic [SDA_CFG_W-1:0] sda_cfg_q;
  logic [STA_CFG_W-1:0] sta_cfg_q;
  logic [STO_CFG_W-1:0] sto_cfg_q;

  // Settings are captured only when a command is taken (R10).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlow_q    <= '0;
      dhigh_q   <= '0;
      sda_cfg_q <= '0;
      sta_cfg_q <= '0;
      sto_cfg_q <= '0;
    end else if (load) begin
      dlow_q    <= div_word[DIV_W-1:0];
      dhigh_q   <= div_word[2*DIV_W-1:DIV_W];
      sda_cfg_q <= tune_word[SDA_CFG_W-1:0];
      sta_cfg_q <= tune_word[SDA_CFG_W +: STA_CFG_W];
      sto_cfg_q <= tune_word[SDA_CFG_W+STA_CFG_W +: STO_CFG_W];
    end
  end

  logic [MW-1:0] l_w, h_w, s_w, u_w, p_w;
  logic [MW-1:0] low_w, high_w, upd_raw, upd_cap, upd_w;
  logic [MW-1:0] su_sta_w, hd_sta_w, su_sto_w;

  always_comb begin
    l_w      = MW'(dlow_q) + MW'(1);
    h_w      = MW'(dhigh_q) + MW'(1);
    s_w      = MW'(sda_cfg_q) + MW'(1);
    u_w      = MW'(sta_cfg_q) + MW'(1);
    p_w      = MW'(sto_cfg_q) + MW'(1);
    low_w    = l_w << 3;
    high_w   = h_w << 3;
    upd_raw  = (l_w * s_w) + MW'(1);
    upd_cap  = low_w - MW'(1);
    upd_w    = (upd_raw > upd_cap) ? upd_cap : upd_raw;
    su_sta_w = ((h_w * u_w) << 3) + MW'(1);
    hd_sta_w = ((h_w * (u_w + MW'(1))) << 3) - MW'(1);
    su_sto_w = ((h_w * p_w) << 3) + MW'(1);
  end

  always_comb begin
    unique case (phase)
      PH_HIGH:   phase_len = CNT_W'(high_w);
      PH_SU_STA: phase_len = CNT_W'(su_sta_w);
      PH_HD_STA: phase_len = CNT_W'(hd_sta_w);
      PH_SU_STO: phase_len = CNT_W'(su_sto_w);
      default:   phase_len = CNT_W'(low_w);
    endcase
    upd_off = CNT_W'(upd_w);
  end

endmodule

// File: rtl/i2cbt_phase_cnt.sv
module i2cbt_phase_cnt #(
  parameter int CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] target,
  output logic [CNT_W-1:0] cnt,
  output logic             at_end
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (run)     cnt <= cnt + CNT_W'(1);
  end

  assign at_end = run && (cnt == target - CNT_W'(1));

  // R2: a running phase never counts past its length
  a_r2_cnt_within_phase: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < target));

endmodule

// File: rtl/i2cbt_seq.sv
module i2cbt_seq
  import i2cbt_pkg::*;
#(
  parameter int CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_wdata,
  input  logic             sda_in,
  input  logic [CNT_W-1:0] cnt,
  input  logic             at_end,
  input  logic [CNT_W-1:0] upd_off,
  output logic             cmd_ready,
  output logic             load,
  output logic             restart,
  output logic             run,
  output bt_phase_e        phase,
  output logic             scl_lo,
  output logic             sda_lo,
  output logic             done,
  output logic             rd_bit
);

  bt_state_e st;
  logic      wbit_q, rd_q;
  logic      busy, cmd_end_here, bus_free, accept, upd_hit;

  always_comb begin
    busy         = !(st == ST_IDLE || st == ST_HOLD);
    cmd_end_here = at_end && (st == ST_HD_STA || st == ST_BIT_HIGH || st == ST_SU_STO);
    cmd_ready    = !busy || cmd_end_here;
    accept       = cmd_valid && cmd_ready;
    bus_free     = (st == ST_IDLE) || (st == ST_SU_STO);
    upd_hit      = (cnt == upd_off - CNT_W'(1));
    run          = busy;
    load         = accept;
    restart      = accept || at_end;
    unique case (st)
      ST_BIT_HIGH: phase = PH_HIGH;
      ST_SU_STA:   phase = PH_SU_STA;
      ST_HD_STA:   phase = PH_HD_STA;
      ST_SU_STO:   phase = PH_SU_STO;
      default:     phase = PH_LOW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      scl_lo <= 1'b0;
      sda_lo <= 1'b0;
      done   <= 1'b0;
      rd_bit <= 1'b0;
      wbit_q <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_RS_LOW: if (at_end) begin
          st     <= ST_SU_STA;
          scl_lo <= 1'b0;
        end
        ST_SU_STA: if (at_end) begin
          st     <= ST_HD_STA;
          sda_lo <= 1'b1;
        end
        ST_HD_STA: if (at_end) begin
          st     <= ST_HOLD;
          scl_lo <= 1'b1;
          done   <= 1'b1;
        end
        ST_BIT_LOW: begin
          if (upd_hit && !rd_q) sda_lo <= !wbit_q;
          if (at_end) begin
            st     <= ST_BIT_HIGH;
            scl_lo <= 1'b0;
          end
        end
        ST_BIT_HIGH: if (at_end) begin
          st     <= ST_HOLD;
          scl_lo <= 1'b1;
          done   <= 1'b1;
          if (rd_q) rd_bit <= sda_in;
        end
        ST_SP_LOW: begin
          if (upd_hit) sda_lo <= 1'b1;
          if (at_end) begin
            st     <= ST_SU_STO;
            scl_lo <= 1'b0;
          end
        end
        ST_SU_STO: if (at_end) begin
          st     <= ST_IDLE;
          sda_lo <= 1'b0;
          done   <= 1'b1;
        end
        default: ;
      endcase

      // A new command overrides the end-of-phase updates above (R9).
      if (accept) begin
        rd_q   <= (cmd_op == OP_READ);
        wbit_q <= cmd_wdata;
        unique case (cmd_op)
          OP_START: begin
            sda_lo <= 1'b0;
            if (bus_free) begin
              st     <= ST_SU_STA;
              scl_lo <= 1'b0;
            end else begin
              st     <= ST_RS_LOW;
              scl_lo <= 1'b1;
            end
          end
          OP_WRITE: begin
            st     <= ST_BIT_LOW;
            scl_lo <= 1'b1;
          end
          OP_READ: begin
            st     <= ST_BIT_LOW;
            scl_lo <= 1'b1;
            sda_lo <= 1'b0;
          end
          default: begin
            st     <= ST_SP_LOW;
            scl_lo <= 1'b1;
          end
        endcase
      end
    end
  end

  // R1: a free bus has both lines released
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!scl_lo && !sda_lo));

  // R2: SCL is released during the high phase of a bit
  a_r2_scl_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BIT_HIGH) |-> !scl_lo);

  // R3: data is steady while SCL is high
  a_r3_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BIT_HIGH && $past(st == ST_BIT_HIGH)) |-> $stable(sda_lo));

  // R4: a read never pulls SDA
  a_r4_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_BIT_LOW || st == ST_BIT_HIGH) && rd_q) |-> !sda_lo);

  // R5: START hold window has SDA low under a released SCL
  a_r5_start_hold_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HD_STA) |-> (sda_lo && !scl_lo));

  // R11: done lasts one clock
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2cbt_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int SDA_CFG_W = 4,
  parameter int STA_CFG_W = 2,
  parameter int STO_CFG_W = 2
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cmd_valid,
  output logic                                     cmd_ready,
  input  logic [1:0]                               cmd_op,
  input  logic                                     cmd_wdata,
  input  logic [2*DIV_W-1:0]                       clk_div,
  input  logic [SDA_CFG_W+STA_CFG_W+STO_CFG_W-1:0] tune,
  input  logic                                     sda_in,
  output logic                                     scl_lo,
  output logic                                     sda_lo,
  output logic                                     done,
  output logic                                     rd_bit
);

  localparam int MAXC  = (STA_CFG_W > STO_CFG_W) ? STA_CFG_W : STO_CFG_W;
  localparam int CNT_W = DIV_W + MAXC + 5;

  logic             load, restart, run, at_end;
  logic [CNT_W-1:0] phase_len, upd_off, cnt;
  bt_phase_e        phase;

  i2cbt_timing #(
    .DIV_W(DIV_W), .SDA_CFG_W(SDA_CFG_W), .STA_CFG_W(STA_CFG_W),
    .STO_CFG_W(STO_CFG_W), .CNT_W(CNT_W)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .load(load), .div_word(clk_div),
    .tune_word(tune), .phase(phase), .phase_len(phase_len), .upd_off(upd_off)
  );

  i2cbt_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .target(phase_len), .cnt(cnt), .at_end(at_end)
  );

  i2cbt_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .sda_in(sda_in), .cnt(cnt), .at_end(at_end),
    .upd_off(upd_off), .cmd_ready(cmd_ready), .load(load), .restart(restart),
    .run(run), .phase(phase), .scl_lo(scl_lo), .sda_lo(sda_lo),
    .done(done), .rd_bit(rd_bit)
  );

endmodule

// File: tb/i2c_bit_timer_tb_top.sv
module i2c_bit_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam logic [1:0] C_START = 2'd0;
  localparam logic [1:0] C_WRITE = 2'd1;
  localparam logic [1:0] C_READ  = 2'd2;
  localparam logic [1:0] C_STOP  = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic cmd_wdata = 1'b0;
  logic [2*DW-1:0] clk_div = '0;
  logic [7:0] tune = '0;
  logic sda_in;
  logic scl_lo, sda_lo, done, rd_bit;
  logic line_drv = 1'b1;

  int n_checks = 0;
  int n_fail = 0;
  int kk = 0;
  int done_at = -1;
  int L, H, S, U, P, D;
  bit finished = 0;

  assign sda_in = !sda_lo && line_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bit_timer #(.DIV_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .clk_div(clk_div), .tune(tune),
    .sda_in(sda_in), .scl_lo(scl_lo), .sda_lo(sda_lo), .done(done), .rd_bit(rd_bit)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic set_cfg(input int dl, input int dh, input int sc, input int uc, input int pc);
    clk_div = {dh[DW-1:0], dl[DW-1:0]};
    tune = {pc[1:0], uc[1:0], sc[3:0]};
    L = dl + 1; H = dh + 1; S = sc + 1; U = uc + 1; P = pc + 1;
    D = (L * S + 1 > 8 * L - 1) ? 8 * L - 1 : L * S + 1;
  endtask

  task automatic step();
    @(negedge clk);
    kk++;
    if (done) done_at = kk;
  endtask

  task automatic send(input logic [1:0] op, input logic b);
    @(negedge clk);
    cmd_op = op; cmd_wdata = b; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    kk = 0;
    done_at = -1;
  endtask

  task automatic wait_sig(input bit pick_scl, output int at);
    logic v0;
    v0 = pick_scl ? scl_lo : sda_lo;
    while (((pick_scl ? scl_lo : sda_lo) == v0) && kk < 20000) step();
    at = kk;
  endtask

  task automatic t_reset();
    chk("R1 scl_lo after reset", scl_lo, 0);
    chk("R1 sda_lo after reset", sda_lo, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 cmd_ready after reset", cmd_ready, 1);
  endtask

  task automatic t_start_idle();
    int at, base;
    send(C_START, 1'b0);
    chk("R5 SCL released at accept", scl_lo, 0);
    wait_sig(0, at);
    chk("R5 SDA fall offset", at, 8 * H * U + 1);
    base = at;
    wait_sig(1, at);
    chk("R5 SCL fall after SDA", at - base, 8 * H * (U + 1) - 1);
    chk("R11 done at START end", done_at, at);
  endtask

  task automatic t_write(input logic b, input bit scr);
    int at;
    bit chg;
    logic [2*DW-1:0] sv_div;
    logic [7:0] sv_tune;
    string rq;
    rq = scr ? "R10" : "R2";
    chg = (sda_lo != !b);
    sv_div = clk_div; sv_tune = tune;
    send(C_WRITE, b);
    if (scr) begin
      step(); step();
      clk_div = '1; tune = '1;
    end
    if (chg) begin
      wait_sig(0, at);
      chk(scr ? "R10 SDA update offset" : "R3 SDA update offset", at, D);
    end
    wait_sig(1, at);
    chk({rq, " SCL rise offset"}, at, 8 * L);
    wait_sig(1, at);
    chk({rq, " SCL fall offset"}, at, 8 * L + 8 * H);
    chk("R11 done at bit end", done_at, 8 * L + 8 * H);
    chk("R3 SDA level after write", sda_lo, int'(!b));
    if (scr) begin
      clk_div = sv_div; tune = sv_tune;
    end
  endtask

  task automatic t_read(input logic v_early);
    int at;
    line_drv = v_early;
    send(C_READ, 1'b0);
    chk("R4 SDA released at accept", sda_lo, 0);
    wait_sig(1, at);
    chk("R2 read SCL rise offset", at, 8 * L);
    while (kk < 8 * L + 8 * H - 1) step();
    line_drv = !v_early;
    wait_sig(1, at);
    chk("R2 read SCL fall offset", at, 8 * L + 8 * H);
    chk("R4 sampled value from last high clock", rd_bit, int'(!v_early));
    chk("R4 SDA still released", sda_lo, 0);
    line_drv = 1'b1;
  endtask

  task automatic t_rstart();
    int at, base;
    send(C_START, 1'b0);
    chk("R6 SDA released at accept", sda_lo, 0);
    chk("R6 SCL held low at accept", scl_lo, 1);
    wait_sig(1, at);
    chk("R6 SCL rise offset", at, 8 * L);
    base = at;
    wait_sig(0, at);
    chk("R6 SDA fall after SCL rise", at - base, 8 * H * U + 1);
    base = at;
    wait_sig(1, at);
    chk("R6 SCL fall after SDA fall", at - base, 8 * H * (U + 1) - 1);
    chk("R11 done at repeated START end", done_at, at);
  endtask

  task automatic t_stop();
    int at, base;
    send(C_STOP, 1'b0);
    wait_sig(0, at);
    chk("R7 SDA low offset", at, D);
    wait_sig(1, at);
    chk("R7 SCL rise offset", at, 8 * L);
    base = at;
    wait_sig(0, at);
    chk("R7 SDA rise after SCL rise", at - base, 8 * H * P + 1);
    chk("R11 done at STOP end", done_at, at);
    chk("R1 ready after STOP", cmd_ready, 1);
    chk("R1 SCL released after STOP", scl_lo, 0);
  endtask

  task automatic t_back_to_back();
    int at;
    send(C_WRITE, 1'b1);
    cmd_op = C_WRITE; cmd_wdata = 1'b0; cmd_valid = 1'b1;
    while (!cmd_ready && kk < 20000) step();
    chk("R9 ready in final clock", kk, 8 * L + 8 * H - 1);
    step();
    chk("R11 done on the accepting edge", done_at, 8 * L + 8 * H);
    cmd_valid = 1'b0;
    kk = 0;
    done_at = -1;
    wait_sig(0, at);
    chk("R3 back-to-back SDA update", at, D);
    wait_sig(1, at);
    chk("R9 SCL low exactly 8l back-to-back", at, 8 * L);
    wait_sig(1, at);
    chk("R2 back-to-back SCL fall", at, 8 * L + 8 * H);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();

    // R8 small dividers with mid-range fields
    set_cfg(2, 1, 2, 1, 0);
    t_start_idle();
    t_write(1'b0, 0);
    t_write(1'b1, 1);
    t_read(1'b1);
    t_write(1'b0, 0);
    t_rstart();
    t_write(1'b1, 0);
    t_read(1'b0);
    t_stop();
    t_start_idle();
    t_back_to_back();
    t_write(1'b1, 0);
    t_stop();

    // R8 zero dividers, SDA offset clamped to 8l-1
    set_cfg(0, 0, 15, 3, 3);
    t_start_idle();
    t_write(1'b1, 0);
    t_write(1'b0, 0);
    t_write(1'b1, 0);
    t_stop();

    // R8 all-ones dividers
    set_cfg((1 << DW) - 1, (1 << DW) - 1, 0, 0, 0);
    t_start_idle();
    t_write(1'b1, 0);
    t_stop();

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule